// File: doc/BRIEF.md
# Timer Host Register Interface

This block sits between an 8-bit host bus and a three-channel interval timer. It turns host bus cycles into per-channel configuration, count values and load strobes. It also serves host reads of each channel's live count, a frozen copy of that count, or a status byte. The counting engines are outside the block. They receive mode, BCD select, the programmed count, an arm strobe and a load strobe. In return they report their live count, their output level and a flag that says a written count has not yet been taken up.

A host access happens in every clock cycle in which the select is high together with the read strobe or the write strobe. Writes take effect at the closing clock edge. Read data is combinational during the read cycle, and the read's side effects land at the closing edge. The host first writes a control word to set a channel's byte format, mode and number base. It then writes the count bytes. To read a stable value it can freeze a channel's count, or freeze the count and status of several channels with one command.

Top module: `pit_host_if`

## Requirements
- R1: After reset every channel has mode 000, binary counting, a programmed count of 0 and the low-then-high byte format. No strobe is active and no latch is pending, so reads return the live count, low byte first.
- R2: Bus cycles are decoded only while `bus_sel` is high. A write to address 3 is a control word. Addresses 0, 1 and 2 reach the data port of channels 0, 1 and 2. A read of address 3, or any cycle without a strobe, returns 0.
- R3: In a control word, bits 7:6 name the channel (3 = read-back command). Bits 5:4 set the byte format: 01 low byte only, 10 high byte only, 11 low then high, 00 = count-latch command. Bits 3:1 set the mode and bit 0 selects BCD. A control word with a non-zero format updates `ch_mode`/`ch_bcd` at the closing edge. It also raises that channel's `ch_arm` for exactly the next cycle.
- R4: A data write completes a count in one of two ways. In a single-byte format, every write does; the other byte is 0. In the two-byte format, every second write does, low byte first. On completion the count appears on `ch_count` at the closing edge, and `ch_load` is high for exactly the following cycle. The first byte of a pair gives no `ch_load`.
- R5: Reads follow the channel's byte format, with the two-byte format alternating low then high. Each channel keeps its read toggle apart from its write toggle, so interleaved reads and writes do not disturb each other.
- R6: A count-latch command captures the channel's live count. Reads then return the frozen value until it has been fully read: one read in a single-byte format, two in the two-byte format. After that, reads return the live count. Mode and BCD do not change.
- R7: A count-latch or status-latch request for a channel that still holds an unread latched value of that kind is ignored; the older value stays.
- R8: In a read-back command (bits 7:6 = 11), bit 5 = 0 latches counts and bit 4 = 0 latches status. Bits 1, 2 and 3 select channels 0, 1 and 2, and several channels latch in the same cycle.
- R9: A latched status byte is {OUT level, null-count flag, format[1:0], mode[2:0], BCD}, with OUT in bit 7. When status and count are both latched, the next read returns the status byte, and the read after it starts the count in its normal byte order.
- R10: A control word with a non-zero format clears that channel's read toggle, write toggle and both pending latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, one access per cycle held high |
| bus_wr | input | 1 | Write strobe, one access per cycle held high |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid during the read cycle |
| ch_mode | output | NCH*3 | Mode per channel, channel i at bits 3i+2:3i |
| ch_bcd | output | NCH | BCD select per channel |
| ch_count | output | NCH*CW | Programmed count per channel |
| ch_load | output | NCH | One-cycle strobe: a complete count was written |
| ch_arm | output | NCH | One-cycle strobe: a control word was written |
| ch_live | input | NCH*CW | Live count from each counting engine |
| ch_out | input | NCH | Output level of each engine |
| ch_null | input | NCH | Null-count flag of each engine |

## Verification
Read data belongs to the cycle in which the read strobe is high. The bench drives each read at a falling edge and samples `bus_rdata` one nanosecond later, before the rising edge that applies the read's side effect. Write effects on `ch_mode`, `ch_bcd` and `ch_count` are due one rising edge after the write cycle, and `ch_load`/`ch_arm` are high only in the cycle that follows. The bench therefore checks every channel output at the falling edge right after each write, and again at later idle edges, where the strobes must be low. Live counts, output levels and null flags change only at falling edges, so a latch captures exactly the value the reference model records.

// File: rtl/pit_bus_pkg.sv
package pit_bus_pkg;

   typedef enum logic [1:0] {
      FMT_LATCH = 2'b00,
      FMT_LO    = 2'b01,
      FMT_HI    = 2'b10,
      FMT_BOTH  = 2'b11
   } fmt_e;

   // field order equals the low six bits of both the control word and status byte
   typedef struct packed {
      fmt_e       fmt;
      logic [2:0] mode;
      logic       bcd;
   } chcfg_t;

   localparam logic [1:0] SEL_READBACK = 2'b11;
   localparam logic [1:0] ADDR_CTRL    = 2'b11;
   localparam int         RB_CNT_BIT   = 5;
   localparam int         RB_ST_BIT    = 4;
   localparam int         RB_CH_LSB    = 1;

endpackage

// File: rtl/pit_cmd_decode.sv
module pit_cmd_decode
   import pit_bus_pkg::*;
#(
   parameter int NCH = 3,
   parameter int DW  = 8
) (
   input  logic           bus_sel,
   input  logic           bus_rd,
   input  logic           bus_wr,
   input  logic [1:0]     bus_addr,
   input  logic [DW-1:0]  bus_wdata,
   output logic [NCH-1:0] cw_load,
   output logic [NCH-1:0] cnt_latch,
   output logic [NCH-1:0] st_latch,
   output logic [NCH-1:0] data_wr,
   output logic [NCH-1:0] data_rd
);

   logic       wr_cyc;
   logic       rd_cyc;
   logic       ctl_cyc;
   logic [1:0] tgt;
   logic [1:0] fmt_f;
   logic       is_rb;

   assign wr_cyc  = bus_sel & bus_wr;
   assign rd_cyc  = bus_sel & bus_rd;
   assign ctl_cyc = wr_cyc & (bus_addr == ADDR_CTRL);
   assign tgt     = bus_wdata[7:6];
   assign fmt_f   = bus_wdata[5:4];
   assign is_rb   = ctl_cyc & (tgt == SEL_READBACK);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic direct;
      logic rb_pick;
      assign direct       = ctl_cyc & (tgt == 2'(i));
      assign rb_pick      = is_rb & bus_wdata[RB_CH_LSB + i];
      assign data_wr[i]   = wr_cyc & (bus_addr == 2'(i));
      assign data_rd[i]   = rd_cyc & (bus_addr == 2'(i));
      assign cw_load[i]   = direct & (fmt_f != FMT_LATCH);
      assign cnt_latch[i] = (direct & (fmt_f == FMT_LATCH)) |
                            (rb_pick & ~bus_wdata[RB_CNT_BIT]);
      assign st_latch[i]  = rb_pick & ~bus_wdata[RB_ST_BIT];
   end

endmodule

// File: rtl/pit_chan_regs.sv
module pit_chan_regs
   import pit_bus_pkg::*;
#(
   parameter int DW = 8,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cw_load,
   input  logic          cnt_latch,
   input  logic          st_latch,
   input  logic          data_wr,
   input  logic          data_rd,
   input  logic [DW-1:0] wdata,
   input  logic [CW-1:0] live,
   input  logic          out_lvl,
   input  logic          null_cnt,
   output logic [DW-1:0] rdata,
   output logic [2:0]    cfg_mode,
   output logic          cfg_bcd,
   output logic [CW-1:0] count_q,
   output logic          load_pulse,
   output logic          arm_pulse
);

   localparam int HW = CW - DW;

   chcfg_t        cfg;
   logic          wtog;
   logic          rtog;
   logic [DW-1:0] lo_hold;
   logic          clv;
   logic [CW-1:0] cl;
   logic          slv;
   logic [DW-1:0] sl;
   logic [CW-1:0] src;
   logic [DW-1:0] cnt_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg        <= '{fmt: FMT_BOTH, mode: 3'd0, bcd: 1'b0};
         wtog       <= 1'b0;
         rtog       <= 1'b0;
         lo_hold    <= '0;
         count_q    <= '0;
         load_pulse <= 1'b0;
         arm_pulse  <= 1'b0;
         clv        <= 1'b0;
         cl         <= '0;
         slv        <= 1'b0;
         sl         <= '0;
      end else begin
         load_pulse <= 1'b0;
         arm_pulse  <= 1'b0;
         if (cw_load) begin
            cfg       <= chcfg_t'(wdata[5:0]);
            wtog      <= 1'b0;
            rtog      <= 1'b0;
            clv       <= 1'b0;
            slv       <= 1'b0;
            arm_pulse <= 1'b1;
         end else begin
            if (cnt_latch && !clv) begin
               cl  <= live;
               clv <= 1'b1;
            end
            if (st_latch && !slv) begin
               sl  <= DW'({out_lvl, null_cnt, cfg});
               slv <= 1'b1;
            end
            if (data_wr) begin
               unique case (cfg.fmt)
                  FMT_LO: begin
                     count_q    <= {{HW{1'b0}}, wdata};
                     load_pulse <= 1'b1;
                  end
                  FMT_HI: begin
                     count_q    <= {wdata, {DW{1'b0}}};
                     load_pulse <= 1'b1;
                  end
                  default: begin
                     if (!wtog) begin
                        lo_hold <= wdata;
                        wtog    <= 1'b1;
                     end else begin
                        count_q    <= {wdata, lo_hold};
                        wtog       <= 1'b0;
                        load_pulse <= 1'b1;
                     end
                  end
               endcase
            end
            if (data_rd) begin
               if (slv) begin
                  slv <= 1'b0;
               end else if (cfg.fmt == FMT_BOTH) begin
                  rtog <= ~rtog;
                  if (rtog) clv <= 1'b0;
               end else begin
                  clv <= 1'b0;
               end
            end
         end
      end
   end

   always_comb begin
      src = clv ? cl : live;
      unique case (cfg.fmt)
         FMT_LO:  cnt_byte = src[DW-1:0];
         FMT_HI:  cnt_byte = src[CW-1:DW];
         default: cnt_byte = rtog ? src[CW-1:DW] : src[DW-1:0];
      endcase
      rdata = slv ? sl : cnt_byte;
   end

   assign cfg_mode = cfg.mode;
   assign cfg_bcd  = cfg.bcd;

   a_r4_load_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |-> $past(data_wr));

   a_r3_arm_follows_cw: assert property (@(posedge clk) disable iff (!rst_n)
      arm_pulse |-> $past(cw_load));

   a_r6_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (clv && !cw_load && !data_rd) |=> (clv && $stable(cl)));

   a_r7_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (slv && st_latch && !cw_load && !data_rd) |=> (slv && $stable(sl)));

   a_r9_status_read_first: assert property (@(posedge clk) disable iff (!rst_n)
      (slv && data_rd && !cw_load && !cnt_latch) |=> ($stable(clv) && $stable(rtog) && !slv));

   a_r10_cw_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cw_load |=> (!clv && !slv && !wtog && !rtog));

endmodule

// File: rtl/pit_host_if.sv
module pit_host_if
   import pit_bus_pkg::*;
#(
   parameter int NCH = 3,
   parameter int DW  = 8,
   parameter int CW  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic [NCH*3-1:0]  ch_mode,
   output logic [NCH-1:0]    ch_bcd,
   output logic [NCH*CW-1:0] ch_count,
   output logic [NCH-1:0]    ch_load,
   output logic [NCH-1:0]    ch_arm,
   input  logic [NCH*CW-1:0] ch_live,
   input  logic [NCH-1:0]    ch_out,
   input  logic [NCH-1:0]    ch_null
);

   if (NCH < 1 || NCH > 3) begin : g_bad_nch
      $error("pit_host_if: NCH must be 1 to 3 (address 3 is the control port)");
   end
   if (DW != 8) begin : g_bad_dw
      $error("pit_host_if: control and status bytes need DW == 8");
   end
   if (CW != 2 * DW) begin : g_bad_cw
      $error("pit_host_if: count must be exactly two bus bytes");
   end

   logic [NCH-1:0] cw_load;
   logic [NCH-1:0] cnt_latch;
   logic [NCH-1:0] st_latch;
   logic [NCH-1:0] data_wr;
   logic [NCH-1:0] data_rd;
   logic [DW-1:0]  ch_rd [NCH];

   pit_cmd_decode #(.NCH(NCH), .DW(DW)) u_dec (
      .bus_sel   (bus_sel),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cw_load   (cw_load),
      .cnt_latch (cnt_latch),
      .st_latch  (st_latch),
      .data_wr   (data_wr),
      .data_rd   (data_rd)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      pit_chan_regs #(.DW(DW), .CW(CW)) u_regs (
         .clk        (clk),
         .rst_n      (rst_n),
         .cw_load    (cw_load[i]),
         .cnt_latch  (cnt_latch[i]),
         .st_latch   (st_latch[i]),
         .data_wr    (data_wr[i]),
         .data_rd    (data_rd[i]),
         .wdata      (bus_wdata),
         .live       (ch_live[i*CW +: CW]),
         .out_lvl    (ch_out[i]),
         .null_cnt   (ch_null[i]),
         .rdata      (ch_rd[i]),
         .cfg_mode   (ch_mode[i*3 +: 3]),
         .cfg_bcd    (ch_bcd[i]),
         .count_q    (ch_count[i*CW +: CW]),
         .load_pulse (ch_load[i]),
         .arm_pulse  (ch_arm[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (bus_sel && bus_rd && bus_addr == 2'(i)) bus_rdata = ch_rd[i];
      end
   end

   a_r2_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_rd) |-> (bus_rdata == '0));

   a_r2_no_strobe_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_sel && bus_wr) |-> (ch_arm == '0 && ch_load == '0));

endmodule

// File: tb/sim_pit_host_if.sv
module sim_pit_host_if;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [8:0]  ch_mode;
   logic [2:0]  ch_bcd;
   logic [47:0] ch_count;
   logic [2:0]  ch_load, ch_arm;
   logic [15:0] live [3];
   logic [2:0]  outs = '0, nulls = '0;
   logic [47:0] ch_live;

   assign ch_live = {live[2], live[1], live[0]};

   always #2 clk = ~clk;

   pit_host_if u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_count(ch_count), .ch_load(ch_load),
      .ch_arm(ch_arm), .ch_live(ch_live), .ch_out(outs), .ch_null(nulls)
   );

   int nchk = 0, nfail = 0;
   bit done = 0;

   // reference model, written from the requirements
   logic [1:0]  m_fmt [3];
   logic [2:0]  m_mode [3];
   logic        m_bcd [3];
   logic        m_wt [3], m_rt [3], m_clv [3], m_slv [3];
   logic [7:0]  m_lo [3], m_sl [3];
   logic [15:0] m_cnt [3], m_cl [3];
   logic [2:0]  e_load, e_arm;
   logic [7:0]  last_rd;

   task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic m_reset();
      for (int i = 0; i < 3; i++) begin
         m_fmt[i] = 2'b11; m_mode[i] = 3'd0; m_bcd[i] = 1'b0;
         m_wt[i] = 0; m_rt[i] = 0; m_clv[i] = 0; m_slv[i] = 0;
         m_lo[i] = '0; m_sl[i] = '0; m_cnt[i] = '0; m_cl[i] = '0;
      end
      e_load = '0; e_arm = '0;
   endtask

   task automatic m_write(input logic [1:0] a, input logic [7:0] d);
      e_load = '0; e_arm = '0;
      if (a == 2'd3) begin
         if (d[7:6] != 2'b11) begin
            int c = int'(d[7:6]);
            if (d[5:4] != 2'b00) begin
               m_fmt[c] = d[5:4]; m_mode[c] = d[3:1]; m_bcd[c] = d[0];
               m_wt[c] = 0; m_rt[c] = 0; m_clv[c] = 0; m_slv[c] = 0; e_arm[c] = 1'b1;
            end else if (!m_clv[c]) begin
               m_cl[c] = live[c]; m_clv[c] = 1;
            end
         end else begin
            for (int i = 0; i < 3; i++) begin
               if (d[i+1]) begin
                  if (!d[5] && !m_clv[i]) begin m_cl[i] = live[i]; m_clv[i] = 1; end
                  if (!d[4] && !m_slv[i]) begin
                     m_sl[i] = {outs[i], nulls[i], m_fmt[i], m_mode[i], m_bcd[i]};
                     m_slv[i] = 1;
                  end
               end
            end
         end
      end else begin
         int c = int'(a);
         case (m_fmt[c])
            2'b01: begin m_cnt[c] = {8'h00, d}; e_load[c] = 1'b1; end
            2'b10: begin m_cnt[c] = {d, 8'h00}; e_load[c] = 1'b1; end
            default: begin
               if (!m_wt[c]) begin m_lo[c] = d; m_wt[c] = 1; end
               else begin m_cnt[c] = {d, m_lo[c]}; m_wt[c] = 0; e_load[c] = 1'b1; end
            end
         endcase
      end
   endtask

   function automatic logic [7:0] m_rdata(input logic [1:0] a);
      logic [15:0] s;
      int c;
      if (a == 2'd3) return 8'h00;
      c = int'(a);
      if (m_slv[c]) return m_sl[c];
      s = m_clv[c] ? m_cl[c] : live[c];
      case (m_fmt[c])
         2'b01:   return s[7:0];
         2'b10:   return s[15:8];
         default: return m_rt[c] ? s[15:8] : s[7:0];
      endcase
   endfunction

   task automatic m_read(input logic [1:0] a);
      int c;
      if (a == 2'd3) return;
      c = int'(a);
      if (m_slv[c]) m_slv[c] = 0;
      else if (m_fmt[c] == 2'b11) begin
         if (m_rt[c]) m_clv[c] = 0;
         m_rt[c] = ~m_rt[c];
      end else m_clv[c] = 0;
   endtask

   task automatic chk_outs(input string tag);
      chk({tag, " mode"}, ch_mode, {m_mode[2], m_mode[1], m_mode[0]});
      chk({tag, " bcd"}, ch_bcd, {m_bcd[2], m_bcd[1], m_bcd[0]});
      chk({tag, " count"}, ch_count, {m_cnt[2], m_cnt[1], m_cnt[0]});
      chk({tag, " load"}, ch_load, e_load);
      chk({tag, " arm"}, ch_arm, e_arm);
   endtask

   task automatic do_write(input logic [1:0] a, input logic [7:0] d, input string tag);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      m_write(a, d);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      chk_outs(tag);
   endtask

   task automatic do_read(input logic [1:0] a, input string tag);
      @(negedge clk);
      bus_sel = 1; bus_rd = 1; bus_addr = a;
      #1;
      last_rd = bus_rdata;
      chk({tag, " rdata"}, bus_rdata, m_rdata(a));
      @(posedge clk);
      m_read(a);
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
      e_load = '0; e_arm = '0;
      chk_outs({tag, " idle"});
   endtask

   task automatic set_live(input int c, input logic [15:0] v);
      @(negedge clk);
      live[c] = v;
   endtask

   initial begin
      for (int i = 0; i < 3; i++) live[i] = '0;
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1 mode", ch_mode, 9'd0);
      chk("R1 bcd", ch_bcd, 3'd0);
      chk("R1 count", ch_count, 48'd0);
      chk("R1 strobes", {ch_load, ch_arm}, 6'd0);
      set_live(0, 16'h1234);
      do_read(2'd0, "R1 low first");
      chk("R1 low byte", last_rd, 8'h34);
      do_read(2'd0, "R1 high second");
      chk("R1 high byte", last_rd, 8'h12);

      // R3: ch1, high-only, mode 5, BCD
      do_write(2'd3, 8'h6B, "R3 cw ch1");
      chk("R3 ch1 mode", ch_mode[5:3], 3'd5);
      chk("R3 ch1 bcd", ch_bcd[1], 1'b1);
      chk("R3 arm ch1", ch_arm, 3'b010);
      // R4: high-only write
      do_write(2'd1, 8'hAB, "R4 hi only");
      chk("R4 ch1 count", ch_count[31:16], 16'hAB00);
      chk("R4 ch1 load", ch_load, 3'b010);
      // R4: two-byte write on ch0, mode 2
      do_write(2'd3, 8'h34, "R3 cw ch0");
      do_write(2'd0, 8'h78, "R4 first byte");
      chk("R4 no load on first byte", ch_load, 3'b000);
      do_write(2'd0, 8'h56, "R4 second byte");
      chk("R4 ch0 count", ch_count[15:0], 16'h5678);
      // R4: low-only on ch2
      do_write(2'd3, 8'h91, "R3 cw ch2 lo");
      do_write(2'd2, 8'hC3, "R4 lo only");
      chk("R4 ch2 count", ch_count[47:32], 16'h00C3);

      // R2: deselected write is not decoded, address 3 reads 0
      @(negedge clk);
      bus_sel = 0; bus_wr = 1; bus_addr = 2'd3; bus_wdata = 8'h3E;
      @(negedge clk);
      bus_wr = 0; e_load = '0; e_arm = '0;
      chk_outs("R2 deselected");
      do_read(2'd3, "R2 ctrl addr read");
      chk("R2 ctrl read zero", last_rd, 8'h00);

      // R5: interleaved reads and writes on ch0
      set_live(0, 16'hA55A);
      do_read(2'd0, "R5 read lo");
      do_write(2'd0, 8'h11, "R5 write lo");
      do_read(2'd0, "R5 read hi");
      chk("R5 hi after write", last_rd, 8'hA5);
      do_write(2'd0, 8'h22, "R5 write hi");
      chk("R5 count", ch_count[15:0], 16'h2211);

      // R6: count latch on ch0
      set_live(0, 16'hBEEF);
      do_write(2'd3, 8'h00, "R6 latch");
      set_live(0, 16'h0102);
      do_read(2'd0, "R6 frozen lo");
      chk("R6 frozen lo", last_rd, 8'hEF);
      do_read(2'd0, "R6 frozen hi");
      chk("R6 frozen hi", last_rd, 8'hBE);
      do_read(2'd0, "R6 live again");
      chk("R6 live lo", last_rd, 8'h02);
      do_read(2'd0, "R6 live hi");

      // R7: second latch ignored
      set_live(0, 16'h1111);
      do_write(2'd3, 8'h00, "R7 latch 1");
      set_live(0, 16'h2222);
      do_write(2'd3, 8'h00, "R7 latch 2");
      do_read(2'd0, "R7 lo");
      chk("R7 kept first", last_rd, 8'h11);
      do_read(2'd0, "R7 hi");

      // R8/R9: read-back count+status for ch0 and ch1
      @(negedge clk); outs = 3'b011; nulls = 3'b010; live[1] = 16'h7788;
      do_write(2'd3, 8'hC6, "R8 readback");
      set_live(0, 16'h0000);
      do_read(2'd0, "R9 status ch0");
      chk("R9 status ch0", last_rd, 8'hB4);
      do_read(2'd0, "R9 count lo ch0");
      chk("R9 count lo", last_rd, 8'h22);
      do_read(2'd1, "R9 status ch1");
      chk("R9 status ch1", last_rd, {2'b11, 2'b10, 3'd5, 1'b1});
      do_read(2'd1, "R9 count ch1");
      chk("R8 ch1 latched", last_rd, 8'h77);
      do_read(2'd0, "R9 count hi ch0");
      // status only on ch2
      do_write(2'd3, 8'hE8, "R8 status only");
      do_read(2'd2, "R8 status ch2");
      do_read(2'd2, "R8 live ch2");

      // R10: control word clears toggle and latch
      do_write(2'd3, 8'h00, "R10 latch");
      do_write(2'd0, 8'h99, "R10 half write");
      do_write(2'd3, 8'h36, "R10 cw");
      do_write(2'd0, 8'h44, "R10 first again");
      chk("R10 no load", ch_load, 3'b000);
      do_read(2'd0, "R10 live read");

      // random phase
      void'($urandom(32'd12345));
      for (int n = 0; n < 600; n++) begin
         int op = int'($urandom_range(0, 9));
         logic [1:0] a = 2'($urandom_range(0, 3));
         if (op < 2) do_write(2'd3, 8'($urandom), "R3 R8 rnd cw");
         else if (op < 4) do_write(2'($urandom_range(0, 2)), 8'($urandom), "R4 rnd data");
         else if (op < 8) do_read(a, "R5 R6 rnd read");
         else begin
            @(negedge clk);
            live[$urandom_range(0, 2)] = 16'($urandom);
            outs = 3'($urandom); nulls = 3'($urandom);
         end
      end

      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

endmodule